// File: doc/BRIEF.md
# Switch ID-Routed Packet Checker

This block makes the handling decision for packets that a switch partition routes by bus/device identifier: Type 0 and Type 1 configuration requests, completions, and ID-routed messages. Each packet is described to the block by its ingress port, its kind, its target bus and device numbers, and a vendor-defined flag. Port 0 is always the upstream port. Downstream port `p` (with `p` from 1 to `NPORT-1`) sits at device number `p-1` on the switch's internal bus.

The block is configured with each port's secondary and subordinate bus numbers, the upstream port's own bus number, a mask of enabled downstream device numbers, an alternative-routing-ID enable, and a per-downstream-port upstream-forwarding enable. The internal bus is the upstream port's secondary bus. A route to a downstream port is valid when the port is enabled and the target bus lies between that port's secondary and subordinate numbers, with both ends included. If port ranges overlap, the lowest index wins.

For every accepted packet, the block returns an encoded action and an egress port. Both are registered one clock after the input strobe. Register storage and packet transport sit outside this block.

Top module: `idr_check`

## Requirements
- R1: `out_valid` follows `in_valid` by exactly one clock, and so do `out_act`/`out_port`. The action codes are forward=0, convert-to-Type-0-and-forward=1, error=2, silent drop=3 and unexpected completion=4. `out_port` is 0 whenever the action is neither forward nor convert. After reset the outputs are 0.
- R2: A configuration request of either type (`in_kind` 0 = Type 0, 1 = Type 1) that arrives on a downstream port yields error.
- R3: A Type 0 request on the upstream port is forwarded to port 0. A Type 1 request on the upstream port that targets the internal bus is converted toward port `dev+1` when device `dev` is enabled. It yields error when the device is disabled or does not exist.
- R4: A Type 1 request on the upstream port whose bus equals an enabled downstream port's secondary bus is converted toward that port. It yields error instead when its device number is nonzero, unless alternative routing IDs are enabled.
- R5: A Type 1 request on the upstream port whose bus falls strictly past a downstream port's secondary bus, up to and including its subordinate bus, is forwarded to that port. Disabled ports are skipped, and overlapping ranges go to the lowest index. A Type 1 request that matches no enabled downstream port yields error.
- R6: A completion (`in_kind` 2) whose bus equals the upstream port's own bus number, or equals the internal bus, yields unexpected completion. This check takes precedence over every other completion rule.
- R7: A completion is forwarded to the downstream port whose range holds its bus. If no downstream port holds the bus, the completion goes to port 0 when the bus lies outside the upstream port's secondary-to-subordinate range. Otherwise it is silently dropped. A completion never yields error.
- R8: A completion whose egress would equal its ingress is forwarded to port 0 when it entered on a downstream port with upstream forwarding enabled. Otherwise it is dropped.
- R9: A message (`in_kind` 3) addressed to a switch port is dropped when vendor-defined (`in_vdm`=1) and yields error otherwise. A message counts as addressed to a switch port when its bus equals the upstream port's bus number, or when it targets an enabled device on the internal bus.
- R10: A message yields error in three cases: it is not vendor-defined and was received on the upstream port; it targets a device on the internal bus that is disabled or does not exist; or it has no valid route.
- R11: A message that would hairpin is forwarded to port 0 when it entered a downstream port with upstream forwarding enabled, and yields error otherwise. Any other routable message is forwarded to its egress port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Packet descriptor strobe |
| in_port | input | PW | Ingress port index, 0 = upstream |
| in_kind | input | 2 | 0 cfg Type 0, 1 cfg Type 1, 2 completion, 3 message |
| in_bus | input | BW | Target bus number |
| in_dev | input | DW | Target device number |
| in_vdm | input | 1 | Message is vendor-defined |
| up_bus | input | BW | Upstream port's own bus number |
| sec_bus | input | NPORT*BW | Secondary bus per port, port p at bits [p*BW +: BW] |
| sub_bus | input | NPORT*BW | Subordinate bus per port, same packing |
| dev_en | input | NPORT-1 | Bit d enables downstream device d (port d+1) |
| ari_en | input | 1 | Alternative routing IDs enabled |
| uf_en | input | NPORT-1 | Bit d enables upstream forwarding on port d+1 |
| out_valid | output | 1 | Decision valid |
| out_act | output | 3 | Encoded action |
| out_port | output | PW | Egress port index |

## Verification
The hardest situations to reach are the ones where several rules compete for one packet. Examples are a completion that both hairpins and would have a valid route, a downstream port that covers a bus but is disabled, and two overlapping enabled ranges. The table-driven stimulus holds one configuration in which port 3 is disabled and only port 1 may forward upstream, so hairpins on ports 1 and 2 give opposite outcomes. Directed steps then rewrite the range and enable inputs to produce overlap, a newly enabled port, and the alternative-routing bypass.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [1:0] {
    K_CFG0 = 2'd0,
    K_CFG1 = 2'd1,
    K_CPL  = 2'd2,
    K_MSG  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    A_FWD   = 3'd0,
    A_CONV  = 3'd1,
    A_ERR   = 3'd2,
    A_DROP  = 3'd3,
    A_UNEXP = 3'd4
  } act_e;

  // inclusive span test shared by range matchers
  function automatic logic in_span(input logic [7:0] b, input logic [7:0] lo,
                                   input logic [7:0] hi);
    return (b >= lo) && (b <= hi);
  endfunction
endpackage

// File: rtl/idr_port_match.sv
module idr_port_match #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] bus,
  input  logic [BW-1:0] lo,
  input  logic [BW-1:0] hi,
  input  logic          en,
  output logic          hit,
  output logic          at_sec
);
  assign hit    = en && (bus >= lo) && (bus <= hi);
  assign at_sec = en && (bus == lo);
endmodule

// File: rtl/idr_route_sel.sv
module idr_route_sel #(
  parameter int NPORT = 4,
  parameter int BW    = 8,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int NDS  = NPORT - 1
) (
  input  logic [BW-1:0]       bus,
  input  logic [NPORT*BW-1:0] sec_bus,
  input  logic [NPORT*BW-1:0] sub_bus,
  input  logic [NDS-1:0]      dev_en,
  output logic                ds_hit,
  output logic [PW-1:0]       ds_idx,
  output logic                ds_at_sec,
  output logic                up_in_rng,
  output logic                on_int_bus
);
  logic [NDS-1:0] hit_v;
  logic [NDS-1:0] sec_v;

  for (genvar g = 0; g < NDS; g++) begin : g_port
    idr_port_match #(.BW(BW)) u_match (
      .bus   (bus),
      .lo    (sec_bus[(g+1)*BW +: BW]),
      .hi    (sub_bus[(g+1)*BW +: BW]),
      .en    (dev_en[g]),
      .hit   (hit_v[g]),
      .at_sec(sec_v[g])
    );
  end

  // lowest enabled index wins on overlapping windows
  always_comb begin
    ds_hit    = 1'b0;
    ds_idx    = '0;
    ds_at_sec = 1'b0;
    for (int p = NDS - 1; p >= 0; p--) begin
      if (hit_v[p]) begin
        ds_hit    = 1'b1;
        ds_idx    = PW'(p + 1);
        ds_at_sec = sec_v[p];
      end
    end
  end

  assign up_in_rng  = (bus >= sec_bus[BW-1:0]) && (bus <= sub_bus[BW-1:0]);
  assign on_int_bus = (bus == sec_bus[BW-1:0]);
endmodule

// File: rtl/idr_policy.sv
module idr_policy
  import idr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int BW    = 8,
  parameter int DW    = 5,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int NDS  = NPORT - 1
) (
  input  logic [1:0]    kind,
  input  logic [PW-1:0] in_port,
  input  logic [BW-1:0] bus,
  input  logic [DW-1:0] dev,
  input  logic          vdm,
  input  logic [BW-1:0] up_bus,
  input  logic [NDS-1:0] dev_en,
  input  logic          ari_en,
  input  logic [NDS-1:0] uf_en,
  input  logic          ds_hit,
  input  logic [PW-1:0] ds_idx,
  input  logic          ds_at_sec,
  input  logic          up_in_rng,
  input  logic          on_int_bus,
  output logic [2:0]    act,
  output logic [PW-1:0] eport,
  output logic          to_switch,
  output logic          hairpin,
  output logic          dst_ok
);
  logic          is_up;
  logic          dev_on;
  logic [PW-1:0] dev_port;
  logic          uf_here;
  logic          to_up_bus;
  logic [PW-1:0] dst;

  always_comb begin
    dev_on   = 1'b0;
    dev_port = '0;
    uf_here  = 1'b0;
    for (int d = 0; d < NDS; d++) begin
      if (dev == DW'(d) && dev_en[d]) begin
        dev_on   = 1'b1;
        dev_port = PW'(d + 1);
      end
      if (in_port == PW'(d + 1)) uf_here = uf_en[d];
    end
  end

  assign is_up     = (in_port == '0);
  assign to_up_bus = (bus == up_bus);
  assign dst_ok    = ds_hit || !up_in_rng;
  assign dst       = ds_hit ? ds_idx : '0;
  assign hairpin   = dst_ok && (dst == in_port);
  assign to_switch = to_up_bus || (on_int_bus && dev_on);

  always_comb begin
    act   = A_ERR;
    eport = '0;
    unique case (kind_e'(kind))
      K_CFG0: begin
        if (is_up) act = A_FWD;
      end
      K_CFG1: begin
        if (is_up) begin
          if (on_int_bus) begin
            if (dev_on) begin
              act   = A_CONV;
              eport = dev_port;
            end
          end else if (ds_hit) begin
            if (!ds_at_sec) begin
              act   = A_FWD;
              eport = ds_idx;
            end else if (dev == '0 || ari_en) begin
              act   = A_CONV;
              eport = ds_idx;
            end
          end
        end
      end
      K_CPL: begin
        if (to_up_bus || on_int_bus) act = A_UNEXP;
        else if (!dst_ok) act = A_DROP;
        else if (hairpin) act = (!is_up && uf_here) ? A_FWD : A_DROP;
        else begin
          act   = A_FWD;
          eport = dst;
        end
      end
      K_MSG: begin
        if (to_switch) act = vdm ? A_DROP : A_ERR;
        else if (is_up && !vdm) act = A_ERR;
        else if (on_int_bus || !dst_ok) act = A_ERR;
        else if (hairpin) act = (!is_up && uf_here) ? A_FWD : A_ERR;
        else begin
          act   = A_FWD;
          eport = dst;
        end
      end
      default: act = A_ERR;
    endcase
  end
endmodule

// File: rtl/idr_check.sv
module idr_check
  import idr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int BW    = 8,
  parameter int DW    = 5,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int NDS  = NPORT - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [PW-1:0]       in_port,
  input  logic [1:0]          in_kind,
  input  logic [BW-1:0]       in_bus,
  input  logic [DW-1:0]       in_dev,
  input  logic                in_vdm,
  input  logic [BW-1:0]       up_bus,
  input  logic [NPORT*BW-1:0] sec_bus,
  input  logic [NPORT*BW-1:0] sub_bus,
  input  logic [NDS-1:0]      dev_en,
  input  logic                ari_en,
  input  logic [NDS-1:0]      uf_en,
  output logic                out_valid,
  output logic [2:0]          out_act,
  output logic [PW-1:0]       out_port
);
  logic          w_ds_hit;
  logic [PW-1:0] w_ds_idx;
  logic          w_ds_at_sec;
  logic          w_up_in_rng;
  logic          w_on_int_bus;
  logic [2:0]    w_act;
  logic [PW-1:0] w_eport;
  logic          w_to_switch;
  logic          w_hairpin;
  logic          w_dst_ok;

  idr_route_sel #(.NPORT(NPORT), .BW(BW)) u_route (
    .bus       (in_bus),
    .sec_bus   (sec_bus),
    .sub_bus   (sub_bus),
    .dev_en    (dev_en),
    .ds_hit    (w_ds_hit),
    .ds_idx    (w_ds_idx),
    .ds_at_sec (w_ds_at_sec),
    .up_in_rng (w_up_in_rng),
    .on_int_bus(w_on_int_bus)
  );

  idr_policy #(.NPORT(NPORT), .BW(BW), .DW(DW)) u_policy (
    .kind      (in_kind),
    .in_port   (in_port),
    .bus       (in_bus),
    .dev       (in_dev),
    .vdm       (in_vdm),
    .up_bus    (up_bus),
    .dev_en    (dev_en),
    .ari_en    (ari_en),
    .uf_en     (uf_en),
    .ds_hit    (w_ds_hit),
    .ds_idx    (w_ds_idx),
    .ds_at_sec (w_ds_at_sec),
    .up_in_rng (w_up_in_rng),
    .on_int_bus(w_on_int_bus),
    .act       (w_act),
    .eport     (w_eport),
    .to_switch (w_to_switch),
    .hairpin   (w_hairpin),
    .dst_ok    (w_dst_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_act   <= A_FWD;
      out_port  <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      out_act   <= w_act;
      out_port  <= w_eport;
    end else begin
      out_valid <= 1'b0;
      out_act   <= A_FWD;
      out_port  <= '0;
    end
  end
endmodule

// File: rtl/idr_check_sva.sv
module idr_check_sva #(
  parameter int NPORT = 4,
  parameter int BW    = 8,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [PW-1:0] in_port,
  input logic [1:0]    in_kind,
  input logic [BW-1:0] in_bus,
  input logic [BW-1:0] up_bus,
  input logic          in_vdm,
  input logic          w_to_switch,
  input logic          w_hairpin,
  input logic          w_dst_ok,
  input logic          out_valid,
  input logic [2:0]    out_act,
  input logic [PW-1:0] out_port
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_no_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_act > 3'd1) |-> (out_port == '0));
  p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_act <= 3'd4);
  p_cfg_ds_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind <= 2'd1 && in_port != '0) |=> (out_act == 3'd2));
  p_conv_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_act == 3'd1) |-> (out_port != '0));
  p_unexp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd2 && in_bus == up_bus) |=> (out_act == 3'd4));
  p_cpl_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd2) |=> (out_act != 3'd2));
  p_cpl_hairpin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd2 && in_bus != up_bus && w_hairpin)
      |=> (out_port == '0));
  p_vdm_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd3 && w_to_switch && in_vdm) |=> (out_act == 3'd3));
  p_msg_noroute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd3 && !w_to_switch && !w_dst_ok) |=> (out_act == 3'd2));
endmodule

bind idr_check idr_check_sva #(.NPORT(NPORT), .BW(BW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_port    (in_port),
  .in_kind    (in_kind),
  .in_bus     (in_bus),
  .up_bus     (up_bus),
  .in_vdm     (in_vdm),
  .w_to_switch(w_to_switch),
  .w_hairpin  (w_hairpin),
  .w_dst_ok   (w_dst_ok),
  .out_valid  (out_valid),
  .out_act    (out_act),
  .out_port   (out_port)
);

// File: tb/sim_idr_check.sv
module sim_idr_check;
  localparam int NPORT = 4;
  localparam int BW = 8;
  localparam int DW = 5;
  localparam int PW = 2;
  localparam int NV = 31;

  // {req4, kind2, port2, bus8, dev5, vdm1, act3, eport2}
  localparam logic [26:0] VEC [NV] = '{
    {4'd2,  2'd0, 2'd1, 8'd3,   5'd0, 1'b0, 3'd2, 2'd0}, // R2
    {4'd2,  2'd1, 2'd2, 8'd7,   5'd0, 1'b0, 3'd2, 2'd0}, // R2
    {4'd3,  2'd0, 2'd0, 8'd2,   5'd0, 1'b0, 3'd0, 2'd0}, // R3
    {4'd3,  2'd1, 2'd0, 8'd2,   5'd1, 1'b0, 3'd1, 2'd2}, // R3
    {4'd3,  2'd1, 2'd0, 8'd2,   5'd2, 1'b0, 3'd2, 2'd0}, // R3 disabled dev
    {4'd3,  2'd1, 2'd0, 8'd2,   5'd7, 1'b0, 3'd2, 2'd0}, // R3 missing dev
    {4'd4,  2'd1, 2'd0, 8'd3,   5'd0, 1'b0, 3'd1, 2'd1}, // R4
    {4'd4,  2'd1, 2'd0, 8'd6,   5'd3, 1'b0, 3'd2, 2'd0}, // R4 nonzero dev
    {4'd5,  2'd1, 2'd0, 8'd5,   5'd4, 1'b0, 3'd0, 2'd1}, // R5 top edge
    {4'd5,  2'd1, 2'd0, 8'd10,  5'd0, 1'b0, 3'd0, 2'd2}, // R5
    {4'd5,  2'd1, 2'd0, 8'd12,  5'd0, 1'b0, 3'd2, 2'd0}, // R5 disabled port
    {4'd5,  2'd1, 2'd0, 8'h40,  5'd0, 1'b0, 3'd2, 2'd0}, // R5 no route
    {4'd6,  2'd2, 2'd1, 8'd1,   5'd0, 1'b0, 3'd4, 2'd0}, // R6
    {4'd6,  2'd2, 2'd0, 8'd2,   5'd9, 1'b0, 3'd4, 2'd0}, // R6
    {4'd7,  2'd2, 2'd0, 8'd4,   5'd0, 1'b0, 3'd0, 2'd1}, // R7
    {4'd7,  2'd2, 2'd1, 8'h50,  5'd0, 1'b0, 3'd0, 2'd0}, // R7
    {4'd7,  2'd2, 2'd1, 8'd12,  5'd0, 1'b0, 3'd3, 2'd0}, // R7 drop
    {4'd8,  2'd2, 2'd2, 8'd8,   5'd0, 1'b0, 3'd3, 2'd0}, // R8
    {4'd8,  2'd2, 2'd1, 8'd4,   5'd0, 1'b0, 3'd0, 2'd0}, // R8
    {4'd8,  2'd2, 2'd0, 8'h50,  5'd0, 1'b0, 3'd3, 2'd0}, // R8
    {4'd9,  2'd3, 2'd1, 8'd2,   5'd0, 1'b1, 3'd3, 2'd0}, // R9
    {4'd9,  2'd3, 2'd1, 8'd2,   5'd1, 1'b0, 3'd2, 2'd0}, // R9
    {4'd9,  2'd3, 2'd2, 8'd1,   5'd0, 1'b1, 3'd3, 2'd0}, // R9
    {4'd10, 2'd3, 2'd0, 8'd4,   5'd0, 1'b0, 3'd2, 2'd0}, // R10
    {4'd11, 2'd3, 2'd0, 8'd4,   5'd0, 1'b1, 3'd0, 2'd1}, // R11
    {4'd10, 2'd3, 2'd1, 8'd2,   5'd2, 1'b1, 3'd2, 2'd0}, // R10
    {4'd10, 2'd3, 2'd1, 8'd12,  5'd0, 1'b1, 3'd2, 2'd0}, // R10
    {4'd11, 2'd3, 2'd2, 8'd7,   5'd0, 1'b1, 3'd2, 2'd0}, // R11
    {4'd11, 2'd3, 2'd1, 8'd3,   5'd0, 1'b0, 3'd0, 2'd0}, // R11
    {4'd11, 2'd3, 2'd2, 8'h60,  5'd0, 1'b0, 3'd0, 2'd0}, // R11
    {4'd11, 2'd3, 2'd1, 8'd8,   5'd0, 1'b0, 3'd0, 2'd2}  // R11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_port = '0;
  logic [1:0] in_kind = '0;
  logic [BW-1:0] in_bus = '0;
  logic [DW-1:0] in_dev = '0;
  logic in_vdm = 1'b0;
  logic [BW-1:0] up_bus = 8'd1;
  logic [NPORT*BW-1:0] sec_bus = {8'd11, 8'd6, 8'd3, 8'd2};
  logic [NPORT*BW-1:0] sub_bus = {8'h20, 8'd10, 8'd5, 8'h20};
  logic [NPORT-2:0] dev_en = 3'b011;
  logic ari_en = 1'b0;
  logic [NPORT-2:0] uf_en = 3'b001;
  logic out_valid;
  logic [2:0] out_act;
  logic [PW-1:0] out_port;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idr_check #(.NPORT(NPORT), .BW(BW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .in_kind(in_kind), .in_bus(in_bus), .in_dev(in_dev), .in_vdm(in_vdm),
    .up_bus(up_bus), .sec_bus(sec_bus), .sub_bus(sub_bus), .dev_en(dev_en),
    .ari_en(ari_en), .uf_en(uf_en), .out_valid(out_valid), .out_act(out_act),
    .out_port(out_port)
  );

  task automatic chk(input int req, input logic [2:0] ea, input logic [PW-1:0] ep);
    checks++;
    if (!out_valid || out_act !== ea || out_port !== ep) begin
      fails++;
      $display("FAIL R%0d: valid=%0b act=%0d port=%0d expected valid=1 act=%0d port=%0d",
               req, out_valid, out_act, out_port, ea, ep);
    end
  endtask

  // drive on a falling edge, one rising edge registers, sample on next fall
  task automatic send(input int req, input logic [1:0] k, input logic [PW-1:0] p,
                      input logic [BW-1:0] b, input logic [DW-1:0] d, input logic v,
                      input logic [2:0] ea, input logic [PW-1:0] ep);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_port = p; in_bus = b; in_dev = d; in_vdm = v;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, ea, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_act !== 3'd0 || out_port !== '0) begin
      fails++;
      $display("FAIL R1: reset valid=%0b act=%0d port=%0d expected 0 0 0",
               out_valid, out_act, out_port);
    end
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][26:23]), VEC[i][22:21], VEC[i][20:19], VEC[i][18:11],
           VEC[i][10:6], VEC[i][5], VEC[i][4:2], VEC[i][1:0]);
    end
    // R1: idle cycle clears valid and zeroes the decision
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_port !== '0) begin
      fails++;
      $display("FAIL R1: idle valid=%0b port=%0d expected 0 0", out_valid, out_port);
    end
    // R4: alternative routing IDs bypass the device-zero rule
    ari_en = 1'b1;
    send(4, 2'd1, 2'd0, 8'd6, 5'd3, 1'b0, 3'd1, 2'd2);
    ari_en = 1'b0;
    // R5: enabling port 3 opens its window
    dev_en = 3'b111;
    send(5, 2'd1, 2'd0, 8'd12, 5'd0, 1'b0, 3'd0, 2'd3);
    send(4, 2'd1, 2'd0, 8'd11, 5'd0, 1'b0, 3'd1, 2'd3);
    // R5 / R7: overlapping windows resolve to lowest index
    sec_bus[3*BW +: BW] = 8'd4;
    sub_bus[3*BW +: BW] = 8'd4;
    send(7, 2'd2, 2'd0, 8'd4, 5'd0, 1'b0, 3'd0, 2'd1);
    send(5, 2'd1, 2'd0, 8'd4, 5'd0, 1'b0, 3'd0, 2'd1);
    // R8: upstream forwarding now enabled on port 2
    uf_en = 3'b011;
    send(8, 2'd2, 2'd2, 8'd8, 5'd0, 1'b0, 3'd0, 2'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule